// File: doc/BRIEF.md
# External Interrupt Capture and Router

This block takes five external interrupt request pins and one machine-check request pin. All of them are active low and may change with no relation to the block clock. Each interrupt source is conditioned by its own programmable sense. A level source is pending only while its pin is held asserted. An edge source latches a sticky pending bit on its asserting edge. Pending sources that are not masked compete under a fixed priority. The block reports the winning source as a 3-bit code with a valid flag.

The winner and the machine-check request are steered by an operating mode. In normal mode the processor interrupt and processor machine-check outputs carry them. In core-disabled mode both processor outputs are held inactive. Interrupts then leave on an active-low PCI INTA line, modelled as a drive-low enable. A select bit sends the machine check either onto that same line or onto a dedicated open-drain machine-check pin. A small write-only register port programs sense, mask and mode, and clears edge-latched requests.

Top module: `ext_irq_router`

## Requirements
- R1: Every request pin (`irq_n_i`, `mc_n_i`) is active low and passes through a two-stage synchronizer. A pin assertion held steady shows at the registered outputs at the third rising clock edge after it is applied, and not before.
- R2: Writing address 0 sets the sense of each source. Bit i = 1 makes source i edge-sensitive and bit i = 0 makes it level-sensitive. The reset value is all level.
- R3: A level-sensitive source is pending exactly while its pin is asserted. Releasing the pin removes it from arbitration.
- R4: An edge-sensitive source sets a sticky pending bit on the high-to-low transition of its pin, and the bit stays set after the pin is released. Writing 1 to bit i at address 3 clears bit i and leaves the other bits alone. An edge that arrives in the same cycle as its clear leaves the bit set.
- R5: Writing address 1 sets the mask, where bit i = 1 means source i is masked. The reset value is all masked. A masked source takes no part in arbitration but keeps its pending state, so it wins again once it is unmasked.
- R6: Fixed priority applies, with source 0 highest and source 4 lowest. `win_id_o` gives the index of the winning source. `win_vld_o` is low, and `win_id_o` is 0, when no source is both pending and unmasked.
- R7: In normal mode (address 2, bit 0 = 0), `core_int_o` equals `win_vld_o` and `core_mc_o` follows the machine-check request. `inta_oe_o` and `mcp_oe_o` stay low.
- R8: In core-disabled mode (address 2, bit 0 = 1), `core_int_o` and `core_mc_o` stay low. `inta_oe_o` is high whenever `win_vld_o` is high.
- R9: In core-disabled mode, address 2 bit 1 chooses the machine-check route. With the bit at 0, the request drives `inta_oe_o`. With the bit at 1, it drives `mcp_oe_o`. `mcp_oe_o` is never high while the bit is 0.
- R10: While reset is high, every output is low. This is the inactive state of every pin, and the open-drain enables are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n_i | input | 5 | External interrupt request pins, active low, asynchronous |
| mc_n_i | input | 1 | Machine-check request pin, active low, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 sense, 1 mask, 2 control, 3 clear |
| reg_wdata_i | input | 5 | Register write data |
| core_int_o | output | 1 | Processor interrupt request, active high |
| core_mc_o | output | 1 | Processor machine-check request, active high |
| inta_oe_o | output | 1 | Drive-low enable of the PCI INTA line |
| mcp_oe_o | output | 1 | Drive-low enable of the dedicated machine-check pin |
| win_id_o | output | 3 | Index of the winning source |
| win_vld_o | output | 1 | A source is pending and unmasked |

## Verification
Two functions can fall in the same clock cycle: the edge detector of a source raising its rise pulse, and a software write of 1 that clears the same source. The bench times a pin assertion so that the clear write is presented exactly in the cycle in which the synchronized edge is detected. It then judges that the source is still reported as the winner after the write. A clear written in a quiet cycle, in contrast, must leave no pending source behind.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_SRC = 5;
    localparam int ID_W    = $clog2(NUM_SRC);

    typedef enum logic [1:0] {
        ADDR_SENSE = 2'd0,
        ADDR_MASK  = 2'd1,
        ADDR_CTRL  = 2'd2,
        ADDR_CLEAR = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic mc_sel;    // 1: machine check on dedicated pin
        logic core_dis;  // 1: core-disabled mode
    } ctrl_t;

    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] id;
    } win_t;

    typedef struct packed {
        logic            core_int;
        logic            core_mc;
        logic            inta_oe;
        logic            mcp_oe;
        logic            vld;
        logic [ID_W-1:0] id;
    } out_t;

    // lowest set index wins; id 0 and vld 0 when nothing eligible
    function automatic win_t pick_lowest(input logic [NUM_SRC-1:0] elig);
        win_t w;
        w = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                w.vld = 1'b1;
                w.id  = ID_W'(i);
            end
        end
        return w;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '1;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/irq_sense.sv
module irq_sense (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic edge_mode,
    input  logic clr,
    output logic pend
);
    logic req_d;
    logic latch_q;
    logic rise;

    assign rise = req & ~req_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d   <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            req_d <= req;
            if (edge_mode) latch_q <= (latch_q & ~clr) | rise;
            else           latch_q <= 1'b0;
        end
    end

    assign pend = edge_mode ? latch_q : req;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] elig,
    output win_t               win
);
    always_comb win = pick_lowest(elig);
endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_n_i,
    input  logic               mc_n_i,
    input  logic               reg_we_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [NUM_SRC-1:0] reg_wdata_i,
    output logic               core_int_o,
    output logic               core_mc_o,
    output logic               inta_oe_o,
    output logic               mcp_oe_o,
    output logic [ID_W-1:0]    win_id_o,
    output logic               win_vld_o
);
    localparam int SW = NUM_SRC + 1;

    logic [SW-1:0]      pins_s;
    logic [NUM_SRC-1:0] req;
    logic               mc_req;
    logic [NUM_SRC-1:0] sense_q;
    logic [NUM_SRC-1:0] mask_q;
    ctrl_t              ctrl_q;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] eligible;
    win_t               win;
    out_t               nxt;
    out_t               out_q;
    logic               ctrl_unused;

    irq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({mc_n_i, irq_n_i}),
        .dout (pins_s)
    );

    assign req    = ~pins_s[NUM_SRC-1:0];
    assign mc_req = ~pins_s[NUM_SRC];

    // register port (write only)
    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q <= '0;
            mask_q  <= '1;
            ctrl_q  <= '0;
        end else if (reg_we_i) begin
            case (reg_addr_e'(reg_addr_i))
                ADDR_SENSE: sense_q <= reg_wdata_i;
                ADDR_MASK:  mask_q  <= reg_wdata_i;
                ADDR_CTRL:  ctrl_q  <= ctrl_t'(reg_wdata_i[1:0]);
                default:    ;
            endcase
        end
    end

    assign ctrl_unused = ^reg_wdata_i[NUM_SRC-1:2];
    assign clr = (reg_we_i && reg_addr_e'(reg_addr_i) == ADDR_CLEAR) ? reg_wdata_i : '0;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_sense u_sense (
            .clk       (clk),
            .rst       (rst),
            .req       (req[i]),
            .edge_mode (sense_q[i]),
            .clr       (clr[i]),
            .pend      (pend[i])
        );
    end

    assign eligible = pend & ~mask_q;

    irq_prio_arb u_arb (
        .elig (eligible),
        .win  (win)
    );

    // output steering
    always_comb begin
        nxt.vld      = win.vld;
        nxt.id       = win.id;
        nxt.core_int = ~ctrl_q.core_dis & win.vld;
        nxt.core_mc  = ~ctrl_q.core_dis & mc_req;
        nxt.inta_oe  = ctrl_q.core_dis & (win.vld | (mc_req & ~ctrl_q.mc_sel));
        nxt.mcp_oe   = ctrl_q.core_dis & mc_req & ctrl_q.mc_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= nxt;
    end

    assign core_int_o = out_q.core_int;
    assign core_mc_o  = out_q.core_mc;
    assign inta_oe_o  = out_q.inta_oe;
    assign mcp_oe_o   = out_q.mcp_oe;
    assign win_id_o   = out_q.id;
    assign win_vld_o  = out_q.vld;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input ctrl_t              ctrl,
    input logic [NUM_SRC-1:0] eligible,
    input logic               core_int_o,
    input logic               core_mc_o,
    input logic               inta_oe_o,
    input logic               mcp_oe_o,
    input logic [ID_W-1:0]    win_id_o,
    input logic               win_vld_o
);
    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !core_int_o && !core_mc_o && !inta_oe_o && !mcp_oe_o && !win_vld_o);

    // R8
    core_masked_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.core_dis |=> !core_int_o && !core_mc_o);

    // R7
    pins_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.core_dis |=> !inta_oe_o && !mcp_oe_o);

    // R8
    inta_follows_chk: assert property (@(posedge clk) disable iff (rst)
        win_vld_o && !core_int_o |-> inta_oe_o);

    // R9
    mcp_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.mc_sel |=> !mcp_oe_o);

    // R6
    top_prio_chk: assert property (@(posedge clk) disable iff (rst)
        eligible[0] |=> win_vld_o && win_id_o == '0);

    // R6
    none_idle_chk: assert property (@(posedge clk) disable iff (rst)
        eligible == '0 |=> !win_vld_o && win_id_o == '0);
endmodule

bind ext_irq_router irq_router_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl_q),
    .eligible   (eligible),
    .core_int_o (core_int_o),
    .core_mc_o  (core_mc_o),
    .inta_oe_o  (inta_oe_o),
    .mcp_oe_o   (mcp_oe_o),
    .win_id_o   (win_id_o),
    .win_vld_o  (win_vld_o)
);

// File: tb/sim_ext_irq_router.sv
`timescale 1ns/1ps
module sim_ext_irq_router;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] irq_n = 5'h1F;
    logic       mc_n = 1'b1;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [4:0] wdata = 5'd0;
    logic       core_int, core_mc, inta_oe, mcp_oe, vld;
    logic [2:0] id;
    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ext_irq_router u0 (
        .clk(clk), .rst(rst), .irq_n_i(irq_n), .mc_n_i(mc_n),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .core_int_o(core_int), .core_mc_o(core_mc), .inta_oe_o(inta_oe),
        .mcp_oe_o(mcp_oe), .win_id_o(id), .win_vld_o(vld)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [4:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic int lowest(input logic [4:0] e);
        for (int i = 0; i < 5; i++) if (e[i]) return i;
        return 0;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 core_int in reset", core_int, 0);
        chk("R10 core_mc in reset", core_mc, 0);
        chk("R10 inta_oe in reset", inta_oe, 0);
        chk("R10 mcp_oe in reset", mcp_oe, 0);
        chk("R10 vld in reset", vld, 0);
        rst = 1'b0;
        irq_n = 5'h00;
        settle();
        chk("R5 reset all masked", vld, 0);

        // R3 / R6 / R7 level sweep
        wr(2'd1, 5'h00);
        for (int p = 0; p < 32; p++) begin
            irq_n = ~5'(p);
            settle();
            chk("R3 level vld", vld, int'(p != 0));
            chk("R6 priority id", id, lowest(5'(p)));
            chk("R7 core_int follows", core_int, int'(p != 0));
        end

        // R1 latency
        irq_n = 5'h1F;
        settle();
        irq_n[2] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 not yet after two edges", core_int, 0);
        @(negedge clk);
        chk("R1 visible at third edge", core_int, 1);
        chk("R1 id", id, 2);
        irq_n[2] = 1'b1;
        settle();
        chk("R3 release drops", vld, 0);

        // R2 / R4 edge sense
        wr(2'd0, 5'h1F);
        settle();
        irq_n[3] = 1'b0;
        repeat (3) @(negedge clk);
        irq_n[3] = 1'b1;
        settle();
        chk("R4 sticky vld", vld, 1);
        chk("R2 edge id", id, 3);
        wr(2'd3, 5'h02);
        settle();
        chk("R4 other clear no effect", id, 3);
        chk("R4 other clear vld", vld, 1);

        // R5 mask keeps pending
        wr(2'd1, 5'h08);
        settle();
        chk("R5 masked vld", vld, 0);
        wr(2'd1, 5'h00);
        settle();
        chk("R5 unmask restores", vld, 1);
        chk("R5 unmask id", id, 3);

        wr(2'd3, 5'h08);
        settle();
        chk("R4 clear vld", vld, 0);

        // R4 coincident edge and clear
        irq_n[1] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr(2'd3, 5'h02);
        irq_n[1] = 1'b1;
        settle();
        chk("R4 edge wins over clear", vld, 1);
        chk("R4 edge wins id", id, 1);
        wr(2'd3, 5'h02);
        settle();
        chk("R4 quiet clear", vld, 0);

        // R5 mask sweep, level sense, all pins asserted
        wr(2'd0, 5'h00);
        irq_n = 5'h00;
        for (int m = 0; m < 32; m++) begin
            wr(2'd1, 5'(m));
            settle();
            chk("R5 mask sweep vld", vld, int'(m != 31));
            chk("R5 mask sweep id", id, lowest(~5'(m)));
        end

        // R7 / R8 / R9 mode sweep
        wr(2'd1, 5'h00);
        for (int c = 0; c < 4; c++) begin
            for (int mc = 0; mc < 2; mc++) begin
                for (int a = 0; a < 2; a++) begin
                    int dis, sel;
                    dis = c & 1;
                    sel = (c >> 1) & 1;
                    irq_n = (a != 0) ? 5'b11011 : 5'h1F;
                    mc_n = (mc == 0);
                    wr(2'd2, 5'(c));
                    settle();
                    chk("R7 R8 core_int", core_int, (1 - dis) * a);
                    chk("R7 R8 core_mc", core_mc, (1 - dis) * mc);
                    chk("R8 R9 inta_oe", inta_oe, dis * int'(a != 0 || (mc != 0 && sel == 0)));
                    chk("R9 mcp_oe", mcp_oe, dis * mc * sel);
                    chk("R6 vld in all modes", vld, a);
                end
            end
        end

        // R10 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 reset drops inta", inta_oe, 0);
        chk("R10 reset drops vld", vld, 0);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule